// File: doc/BRIEF.md
# Disk DMA Channel Control Register Block

This block is the register front end of a multi-channel disk DMA engine. A 16-bit memory-mapped bus reaches one global lock byte and, for each channel, a small file of registers. Software uses them to set the transfer mode, arm a packet, hold the engine in reset or mask its interrupt. The descriptor fetch and the data movement are outside the block. Toward that logic each channel has one start pulse and one engine-reset level. Back from it come four event inputs: bus error, stray interrupt, halt and packet done.

Each channel runs a small state machine. The states are CH_IDLE (plain register mode), CH_LAUNCH (the one cycle in which the start pulse is driven), CH_BUSY (packet running) and CH_RESET (engine held in reset). The transitions are:
- CH_IDLE goes to CH_LAUNCH on a control write with the go bit set, only while the global lock holds the unlock key.
- CH_LAUNCH and CH_BUSY go to CH_BUSY by default.
- CH_LAUNCH and CH_BUSY go to CH_IDLE on packet done, or on a control write with the go bit clear.
- Any state goes to CH_RESET on a control write with the reset bit set.
- CH_RESET goes to CH_IDLE on a control write with the reset bit clear.

Event flags are sticky. A status read returns them and clears them. The channel interrupt is raised whenever any flag is set and the mask bit is clear.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, each channel's control word reads 0x0100 (interrupt masked, PIO mode 0, idle), every other channel register and the lock byte read 0, and eng_start, eng_reset and irq are low.
- R2: Channel n occupies the 32-byte window at 0x80 + 0x20*n. The descriptor count at offset 0x04, pointer low half at 0x0C, pointer high half at 0x0E, lookup word at 0x10, input FIFO threshold at 0x14 and output FIFO threshold at 0x16 read back what was written. Writes to one channel leave the other unchanged, and unmapped offsets and writes to status read as no change.
- R3: The lock byte sits at address 0xC7 (bits 7:0 of the bus). It reads back its value, and a go request is honoured only while it holds 7.
- R4: A control write with bit 7 (go) set and bit 5 clear, made while the channel is idle and the lock holds 7, drives eng_start high for exactly the next cycle. Control bit 7 then reads 1 until the channel leaves the running states.
- R5: A go request is ignored while the channel is running or in reset. In particular, the write that leaves reset never starts the engine.
- R6: A control write with bit 5 set enters reset from any state. eng_reset stays high and control bit 5 reads 1 until a control write with bit 5 clear returns the channel to idle. The status flags are cleared on entry to reset and held at 0 throughout it.
- R7: A control write with bit 7 clear while the channel is running returns it to idle with no start pulse and without setting the done flag.
- R8: Status bits 0 (bus error), 4 (stray interrupt) and 6 (halt) latch their event inputs in any state but reset. Bit 2 is set by packet done while the channel is running, and that event also returns the channel to idle.
- R9: A status read (offset 0x02) returns the latched flags and clears them at the same clock edge. An event arriving in the same cycle as the read survives the clear.
- R10: irq is high exactly when the status flags are nonzero and control bit 8 (mask) is 0.
- R11: Control bits 8 and 1:0 are stored from every control write, whatever the go and reset bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (status read clears) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr and bus_rd |
| ev_buserr | input | NCH | Per-channel bus or parity error event |
| ev_stray | input | NCH | Per-channel stray interrupt event |
| ev_halt | input | NCH | Per-channel halt event |
| ev_done | input | NCH | Per-channel packet done event |
| eng_start | output | NCH | One-cycle start pulse to the engine |
| eng_reset | output | NCH | Engine reset level |
| irq | output | NCH | Masked per-channel interrupt |

## Verification
The hardest cases to reach from the ports are the collisions. One is an event landing in the very cycle that a status read clears the flags. Another is a go request arriving in the same write that releases the engine from reset. A third is packet done coinciding with a reset write. The stimulus sets up each one deliberately, putting the event pulse and the bus access in the same cycle after first parking the channel in the needed state. A behavioural model then follows every cycle, so any difference in start, reset or interrupt timing shows up at once.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_LAUNCH = 2'd1,
        CH_BUSY   = 2'd2,
        CH_RESET  = 2'd3
    } ch_state_e;

    // width of the offset inside one channel window
    localparam int OFS_W = 5;

    localparam logic [OFS_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [OFS_W-1:0] OFS_STAT = 5'h02;
    localparam logic [OFS_W-1:0] OFS_CNT  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_PLO  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_PHI  = 5'h0E;
    localparam logic [OFS_W-1:0] OFS_LUT  = 5'h10;
    localparam logic [OFS_W-1:0] OFS_FIN  = 5'h14;
    localparam logic [OFS_W-1:0] OFS_FOUT = 5'h16;

    // control bits
    localparam int CB_MASK = 8;
    localparam int CB_GO   = 7;
    localparam int CB_RST  = 5;

    // status bits
    localparam int SB_BUSERR = 0;
    localparam int SB_FIN    = 2;
    localparam int SB_STRAY  = 4;
    localparam int SB_HALT   = 6;
    localparam int STAT_W    = 8;

    localparam logic [7:0] LOCK_KEY = 8'd7;
endpackage

// File: rtl/dcc_lock.sv
`timescale 1ns/1ps
module dcc_lock
    import dcc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter logic [AW-1:0] ADDR = 'hC7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wbyte,
    output logic [DW-1:0] rdata,
    output logic          unlocked
);
    logic [7:0] key_q;
    logic       hit;

    assign hit = (addr == ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            key_q <= '0;
        else if (wr && hit)
            key_q <= wbyte;
    end

    assign unlocked = (key_q == LOCK_KEY);
    assign rdata    = (rd && hit) ? DW'(key_q) : '0;
endmodule

// File: rtl/dcc_flags.sv
`timescale 1ns/1ps
module dcc_flags #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          rd_clr,
    input  logic [FW-1:0] set,
    output logic [FW-1:0] flags
);
    // set beats a read clear; a reset clear beats everything
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else if (clr_all)
            flags <= '0;
        else
            flags <= (rd_clr ? '0 : flags) | set;
    end
endmodule

// File: rtl/dcc_chan.sv
`timescale 1ns/1ps
module dcc_chan
    import dcc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic             rd,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    input  logic             unlocked,
    input  logic             ev_buserr,
    input  logic             ev_stray,
    input  logic             ev_halt,
    input  logic             ev_done,
    output logic [DW-1:0]    rdata,
    output logic             start,
    output logic             eng_rst,
    output logic             irq
);
    ch_state_e state_q, state_d;

    logic              mask_q;
    logic [1:0]        pio_q;
    logic [DW-1:0]     cnt_q, plo_q, phi_q, lut_q, fin_q, fout_q;
    logic [STAT_W-1:0] stat, evts;
    logic              wr_ctrl, rst_req, go_req, active, busy, fin_evt;

    assign wr_ctrl = sel && wr && (ofs == OFS_CTRL);
    assign rst_req = wr_ctrl && wdata[CB_RST];
    assign go_req  = wr_ctrl && wdata[CB_GO];
    assign active  = (state_q == CH_LAUNCH) || (state_q == CH_BUSY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (rst_req)
                    state_d = CH_RESET;
                else if (go_req && unlocked)
                    state_d = CH_LAUNCH;
            end
            CH_LAUNCH, CH_BUSY: begin
                if (rst_req)
                    state_d = CH_RESET;
                else if (wr_ctrl && !wdata[CB_GO])
                    state_d = CH_IDLE;
                else if (ev_done)
                    state_d = CH_IDLE;
                else
                    state_d = CH_BUSY;
            end
            CH_RESET: begin
                if (wr_ctrl && !wdata[CB_RST])
                    state_d = CH_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        start   = (state_q == CH_LAUNCH);
        eng_rst = (state_q == CH_RESET);
        busy    = active;
        irq     = (|stat) && !mask_q;
    end

    assign fin_evt = active && ev_done && !rst_req;

    always_comb begin
        evts            = '0;
        evts[SB_BUSERR] = ev_buserr;
        evts[SB_FIN]    = fin_evt;
        evts[SB_STRAY]  = ev_stray;
        evts[SB_HALT]   = ev_halt;
    end

    dcc_flags #(.FW(STAT_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all ((state_q == CH_RESET) || rst_req),
        .rd_clr  (sel && rd && (ofs == OFS_STAT)),
        .set     (evts),
        .flags   (stat)
    );

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            pio_q  <= '0;
            cnt_q  <= '0;
            plo_q  <= '0;
            phi_q  <= '0;
            lut_q  <= '0;
            fin_q  <= '0;
            fout_q <= '0;
        end else if (sel && wr) begin
            case (ofs)
                OFS_CTRL: begin
                    mask_q <= wdata[CB_MASK];
                    pio_q  <= wdata[1:0];
                end
                OFS_CNT:  cnt_q  <= wdata;
                OFS_PLO:  plo_q  <= wdata;
                OFS_PHI:  phi_q  <= wdata;
                OFS_LUT:  lut_q  <= wdata;
                OFS_FIN:  fin_q  <= wdata;
                OFS_FOUT: fout_q <= wdata;
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (sel && rd) begin
            case (ofs)
                OFS_CTRL: begin
                    rdata[CB_MASK] = mask_q;
                    rdata[CB_GO]   = busy;
                    rdata[CB_RST]  = eng_rst;
                    rdata[1:0]     = pio_q;
                end
                OFS_STAT: rdata = DW'(stat);
                OFS_CNT:  rdata = cnt_q;
                OFS_PLO:  rdata = plo_q;
                OFS_PHI:  rdata = phi_q;
                OFS_LUT:  rdata = lut_q;
                OFS_FIN:  rdata = fin_q;
                OFS_FOUT: rdata = fout_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl
    import dcc_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter logic [AW-1:0] CH_BASE   = 'h80,
    parameter logic [AW-1:0] LOCK_ADDR = 'hC7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] ev_buserr,
    input  logic [NCH-1:0] ev_stray,
    input  logic [NCH-1:0] ev_halt,
    input  logic [NCH-1:0] ev_done,
    output logic [NCH-1:0] eng_start,
    output logic [NCH-1:0] eng_reset,
    output logic [NCH-1:0] irq
);
    localparam int BW = AW - OFS_W;
    localparam logic [BW-1:0] BASE_BLK = CH_BASE[AW-1:OFS_W];

    logic          unlocked;
    logic [DW-1:0] lock_rd;
    logic [DW-1:0] ch_rd [NCH];

    dcc_lock #(.AW(AW), .DW(DW), .ADDR(LOCK_ADDR)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wbyte    (bus_wdata[7:0]),
        .rdata    (lock_rd),
        .unlocked (unlocked)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [BW-1:0] MY_BLK = BASE_BLK + BW'(g);
        logic sel;
        assign sel = (bus_addr[AW-1:OFS_W] == MY_BLK);

        dcc_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (sel),
            .wr        (bus_wr),
            .rd        (bus_rd),
            .ofs       (bus_addr[OFS_W-1:0]),
            .wdata     (bus_wdata),
            .unlocked  (unlocked),
            .ev_buserr (ev_buserr[g]),
            .ev_stray  (ev_stray[g]),
            .ev_halt   (ev_halt[g]),
            .ev_done   (ev_done[g]),
            .rdata     (ch_rd[g]),
            .start     (eng_start[g]),
            .eng_rst   (eng_reset[g]),
            .irq       (irq[g])
        );
    end

    always_comb begin
        bus_rdata = lock_rd;
        for (int i = 0; i < NCH; i++)
            bus_rdata = bus_rdata | ch_rd[i];
    end
endmodule

// File: rtl/dcc_chk.sv
`timescale 1ns/1ps
module dcc_chk
    import dcc_pkg::*;
#(
    parameter int NCH = 2,
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter logic [AW-1:0] CH_BASE = 'h80
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_wdata,
    input logic [NCH-1:0] ev_buserr,
    input logic [NCH-1:0] ev_stray,
    input logic [NCH-1:0] ev_halt,
    input logic [NCH-1:0] ev_done,
    input logic [NCH-1:0] eng_start,
    input logic [NCH-1:0] eng_reset,
    input logic [NCH-1:0] irq
);
    AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_start)); // R4

    for (genvar c = 0; c < NCH; c++) begin : g_c
        localparam logic [AW-1:0] CTL_A = CH_BASE + AW'(c * (1 << OFS_W));
        localparam logic [AW-1:0] STA_A = CTL_A + AW'(2);

        AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |=> !eng_start[c]); // R4

        AST_START_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |-> $past(bus_wr && bus_addr == CTL_A
                                   && bus_wdata[CB_GO] && !bus_wdata[CB_RST])); // R4

        AST_NO_START_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
            eng_reset[c] |=> !eng_start[c]); // R5

        AST_RESET_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            eng_reset[c] |-> !irq[c]); // R6

        AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == CTL_A && bus_wdata[CB_MASK]) |=> !irq[c]); // R10

        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && bus_addr == STA_A && !ev_buserr[c] && !ev_stray[c]
             && !ev_halt[c] && !ev_done[c]) |=> !irq[c]); // R9
    end
endmodule

bind dma_chan_ctl dcc_chk #(.NCH(NCH), .AW(AW), .DW(DW), .CH_BASE(CH_BASE)) u_chk (.*);

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;
    localparam int NCH = 2;
    localparam logic [7:0] C0 = 8'h80, C1 = 8'hA0, LK = 8'hC7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NCH-1:0] ev_buserr = '0, ev_stray = '0, ev_halt = '0, ev_done = '0;
    logic [NCH-1:0] eng_start, eng_reset, irq;

    always #2.5 clk = ~clk;

    dma_chan_ctl u0 (.*);

    int checks = 0, errors = 0;
    bit running = 1'b0;

    // reference model: 0 idle, 1 launch, 2 busy, 3 reset
    int m_state[NCH], m_mask[NCH], m_pio[NCH], m_st[NCH];
    int m_reg[NCH][16];
    int m_lock;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(logic [7:0] a);
        int v;
        if (a == LK) return m_lock;
        for (int c = 0; c < NCH; c++) begin
            int base, off;
            base = 'h80 + 32 * c;
            off = int'(a) - base;
            if (off >= 0 && off < 32) begin
                if (off == 0) begin
                    v = (m_mask[c] << 8) | (m_pio[c]);
                    if (m_state[c] == 1 || m_state[c] == 2) v |= 'h80;
                    if (m_state[c] == 3) v |= 'h20;
                    return v;
                end
                if (off == 2) return m_st[c];
                if (off == 4 || off == 'hC || off == 'hE || off == 'h10 ||
                    off == 'h14 || off == 'h16) return m_reg[c][off/2];
                return 0;
            end
        end
        return 0;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_state[c] = 0; m_mask[c] = 1; m_pio[c] = 0; m_st[c] = 0;
            for (int k = 0; k < 16; k++) m_reg[c][k] = 0;
        end
        m_lock = 0;
    endtask

    task automatic model_step();
        int new_lock;
        new_lock = m_lock;
        if (bus_wr && bus_addr == LK) new_lock = bus_wdata[7:0];
        for (int c = 0; c < NCH; c++) begin
            int base, off, ns, ev;
            bit sel, cw, rw, act, fin;
            base = 'h80 + 32 * c;
            off = int'(bus_addr) - base;
            sel = (off >= 0 && off < 32);
            cw = bus_wr && sel && off == 0;
            rw = cw && bus_wdata[5];
            act = (m_state[c] == 1 || m_state[c] == 2);
            ns = m_state[c];
            if (m_state[c] == 3) begin
                if (cw && !bus_wdata[5]) ns = 0;
            end else if (rw) ns = 3;
            else if (m_state[c] == 0) begin
                if (cw && bus_wdata[7] && m_lock == 7) ns = 1;
            end else begin
                if (cw && !bus_wdata[7]) ns = 0;
                else if (ev_done[c]) ns = 0;
                else ns = 2;
            end
            fin = act && ev_done[c] && !rw;
            ev = (ev_buserr[c] ? 1 : 0) | (fin ? 4 : 0) | (ev_stray[c] ? 16 : 0) | (ev_halt[c] ? 64 : 0);
            if (m_state[c] == 3 || rw) m_st[c] = 0;
            else begin
                if (bus_rd && sel && off == 2) m_st[c] = 0;
                m_st[c] |= ev;
            end
            if (cw) begin
                m_mask[c] = bus_wdata[8];
                m_pio[c] = bus_wdata[1:0];
            end
            if (bus_wr && sel && (off == 4 || off == 'hC || off == 'hE || off == 'h10 ||
                                  off == 'h14 || off == 'h16))
                m_reg[c][off/2] = bus_wdata;
            m_state[c] = ns;
        end
        m_lock = new_lock;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // per-cycle comparison of the engine-facing outputs
    always @(negedge clk) begin
        if (rst_n && running) begin
            for (int c = 0; c < NCH; c++) begin
                chk("R4 eng_start vs model", eng_start[c], m_state[c] == 1);
                chk("R6 eng_reset vs model", eng_reset[c], m_state[c] == 3);
                chk("R10 irq vs model", irq[c], (m_st[c] != 0) && (m_mask[c] == 0));
            end
        end
    end

    // ev bits: [0] buserr [1] stray [2] halt [3] done
    task automatic cyc(bit w, bit r, logic [7:0] a, logic [15:0] d,
                       logic [3:0] e0, logic [3:0] e1, string tag, int exp, bit use_exp);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        ev_buserr = {e1[0], e0[0]}; ev_stray = {e1[1], e0[1]};
        ev_halt = {e1[2], e0[2]}; ev_done = {e1[3], e0[3]};
        #1;
        if (r) begin
            chk({tag, " read vs model"}, bus_rdata, model_read(a));
            if (use_exp) chk(tag, bus_rdata, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        cyc(1'b1, 1'b0, a, d, 4'h0, 4'h0, "", 0, 1'b0);
    endtask
    task automatic rd(logic [7:0] a, int exp, string tag);
        cyc(1'b0, 1'b1, a, '0, 4'h0, 4'h0, tag, exp, 1'b1);
    endtask
    task automatic idle();
        cyc(1'b0, 1'b0, '0, '0, 4'h0, 4'h0, "", 0, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R1 reset values
        rd(C0 + 8'h00, 'h0100, "R1 ctrl ch0");
        rd(C1 + 8'h00, 'h0100, "R1 ctrl ch1");
        rd(C0 + 8'h02, 0, "R1 status");
        rd(C1 + 8'h04, 0, "R1 count");
        rd(LK, 0, "R1 lock");
        chk("R1 irq low", irq, 0);

        // R2 register decode
        wr(C0 + 8'h04, 16'h0001);
        wr(C0 + 8'h0C, 16'hBEEF);
        wr(C0 + 8'h0E, 16'h1234);
        wr(C0 + 8'h10, 16'h5A5A);
        wr(C0 + 8'h14, 16'h0100);
        wr(C0 + 8'h16, 16'h0180);
        wr(C1 + 8'h04, 16'h0002);
        wr(C0 + 8'h02, 16'hFFFF);
        rd(C0 + 8'h04, 'h0001, "R2 count");
        rd(C0 + 8'h0C, 'hBEEF, "R2 ptr lo");
        rd(C0 + 8'h0E, 'h1234, "R2 ptr hi");
        rd(C0 + 8'h10, 'h5A5A, "R2 lookup");
        rd(C0 + 8'h14, 'h0100, "R2 fifo in");
        rd(C0 + 8'h16, 'h0180, "R2 fifo out");
        rd(C1 + 8'h04, 'h0002, "R2 count ch1");
        rd(C1 + 8'h0C, 0, "R2 ch1 untouched");
        rd(C0 + 8'h02, 0, "R2 status write ignored");
        rd(C0 + 8'h06, 0, "R2 unmapped");

        // R11 mode and mask stored
        wr(C0, 16'h0003);
        rd(C0, 'h0003, "R11 ctrl stored");

        // R3 lock gating
        wr(C0, 16'h0083);
        idle();
        chk("R3 no start when locked", eng_start[0], 0);
        rd(C0, 'h0003, "R3 idle after locked go");
        wr(LK, 16'h0005);
        wr(C0, 16'h0083);
        idle();
        chk("R3 no start with wrong key", eng_start[0], 0);
        wr(LK, 16'h0007);
        rd(LK, 7, "R3 lock readback");

        // R4 start pulse
        wr(C0, 16'h0083);
        idle();
        chk("R4 start pulse", eng_start[0], 1);
        chk("R4 other channel quiet", eng_start[1], 0);
        rd(C0, 'h0083, "R4 busy bit");
        chk("R4 pulse one cycle", eng_start[0], 0);

        // R5 go while busy ignored
        wr(C0, 16'h0083);
        idle();
        chk("R5 no start while busy", eng_start[0], 0);

        // R8 done completes, R10 irq
        cyc(1'b0, 1'b0, '0, '0, 4'h8, 4'h0, "", 0, 1'b0);
        idle();
        chk("R10 irq on done", irq[0], 1);
        rd(C0, 'h0003, "R8 idle after done");
        rd(C0 + 8'h02, 'h04, "R8 done flag");
        idle();
        rd(C0 + 8'h02, 0, "R9 cleared by read");
        chk("R9 irq dropped", irq[0], 0);

        // R8 error flags on masked channel 1, R10
        cyc(1'b0, 1'b0, '0, '0, 4'h0, 4'h5, "", 0, 1'b0);
        idle();
        chk("R10 masked irq", irq[1], 0);
        rd(C1 + 8'h02, 'h41, "R8 error flags");
        // R9 event in same cycle as clearing read
        cyc(1'b0, 1'b0, '0, '0, 4'h0, 4'h2, "", 0, 1'b0);
        cyc(1'b0, 1'b1, C1 + 8'h02, '0, 4'h0, 4'h4, "R9 read with event", 'h10, 1'b1);
        rd(C1 + 8'h02, 'h40, "R9 event survives clear");
        rd(C1 + 8'h02, 0, "R9 second clear");

        // R7 abort to register mode
        wr(C0, 16'h0083);
        idle();
        wr(C0, 16'h0003);
        idle();
        rd(C0, 'h0003, "R7 idle after abort");
        rd(C0 + 8'h02, 0, "R7 no done flag");

        // R6 reset from idle, events held off
        wr(C0, 16'h0123);
        idle();
        chk("R6 reset level", eng_reset[0], 1);
        rd(C0, 'h0123, "R6 reset bit reads");
        cyc(1'b0, 1'b0, '0, '0, 4'h1, 4'h0, "", 0, 1'b0);
        rd(C0 + 8'h02, 0, "R6 flags held in reset");
        wr(C0, 16'h01A3);
        idle();
        chk("R5 no start from reset", eng_start[0], 0);
        chk("R6 still in reset", eng_reset[0], 1);
        wr(C0, 16'h0083);
        idle();
        chk("R5 release write does not start", eng_start[0], 0);
        chk("R6 reset released", eng_reset[0], 0);
        rd(C0, 'h0003, "R6 idle after release");

        // R6 reset from busy, done in same cycle
        wr(C0, 16'h0083);
        idle();
        cyc(1'b1, 1'b0, C0, 16'h0023, 4'h8, 4'h0, "", 0, 1'b0);
        idle();
        chk("R6 reset from busy", eng_reset[0], 1);
        wr(C0, 16'h0003);
        rd(C0 + 8'h02, 0, "R6 done lost to reset");

        // R4 channel 1 independently
        wr(C1, 16'h0083);
        idle();
        chk("R4 ch1 start", eng_start[1], 1);
        chk("R4 ch0 quiet", eng_start[0], 0);
        cyc(1'b0, 1'b0, '0, '0, 4'h0, 4'h8, "", 0, 1'b0);
        idle();
        rd(C1 + 8'h02, 'h04, "R8 ch1 done");

        // R3 relock
        wr(LK, 16'h0000);
        wr(C0, 16'h0083);
        idle();
        chk("R3 relocked no start", eng_start[0], 0);
        idle();

        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule